// File: doc/BRIEF.md
# Closed-Caption Data Slicer

This block recovers caption bytes from a stream of digitized composite-video samples, one 8-bit sample per clock. A line pulse and a field pulse mark the start of each line and each field. Lines are counted from the field pulse. On the one line whose count matches a programmable value, the block measures the clock run-in burst to set a data threshold. It then compares later samples against that threshold at bit-cell centres. It searches for a zero-zero-one start pattern and assembles the next sixteen bits into two bytes. Each byte carries its own odd-parity error flag.

Two thresholds are produced, and each has its own manual/automatic select. The data threshold can be the midpoint of the run-in peak and trough, or a value written by software. The sync threshold can be the midpoint of the lowest sync-tip sample and the blanking level, or a written value. The sync threshold drives a registered sync-slice output. A sticky ready flag announces a new byte pair. Software clears it with a status-read strobe.

Top module: `cc_slicer`

## Requirements
- R1: Lines are counted from the field pulse `vsync`, and the first `hsync` after it starts line 1. Capture happens only on the line whose count equals `cfg_line`.
- R2: Sample position 0 is the cycle after `hsync`. On the selected line, the automatic data level becomes floor((max+min)/2) of the samples at positions RUNIN_START to RUNIN_END-1 (16..39 by default). It is latched at position RUNIN_END. It reads 0x80 after reset and is shown on `data_level` when `data_auto`=1.
- R3: When `data_auto`=0, `data_level` equals `data_level_man`, and that value is the threshold used for slicing.
- R4: A bit is 1 when the sample is >= the data level. Bit k is sampled at position RUNIN_END+1+floor(P/2)+k*P, where P is `cfg_bit_period`.
- R5: Data starts with the bit that follows the first occurrence of the sampled pattern 0,0,1. Earlier bits, including partial matches, are discarded.
- R6: The first 8 data bits form `rx_byte0` with the first bit as bit 0. The next 8 bits form `rx_byte1` in the same order. Both bytes hold their value until the next capture.
- R7: `par_err0`/`par_err1` is 1 when the matching byte holds an even number of ones (odd parity fails). Otherwise it is 0.
- R8: `data_ready` goes to 1 in the same cycle as the bytes. It stays 1 until a `status_rd` cycle clears it. A capture in the same cycle as a read wins. It reads 0 after reset.
- R9: On every line, the automatic sync level becomes floor((min of positions 0..SYNC_LEN-1 + sample at BLANK_POS)/2). It reads 0x40 after reset. `sync_level` shows it when `sync_auto`=1 and shows `sync_level_man` otherwise.
- R10: `sync_slice` is 1 in the cycle after a sample strictly below `sync_level`. It is 0 after a sample at or above it.
- R11: After reset, `rx_byte0` and `rx_byte1` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| vid | input | 8 | Digitized composite-video sample |
| hsync | input | 1 | Line start pulse |
| vsync | input | 1 | Field start pulse |
| cfg_line | input | LINE_W | Line number carrying data |
| cfg_bit_period | input | PER_W | Bit cell length in clocks |
| data_auto | input | 1 | 1: automatic data level |
| data_level_man | input | 8 | Manual data level |
| sync_auto | input | 1 | 1: automatic sync level |
| sync_level_man | input | 8 | Manual sync level |
| status_rd | input | 1 | Status-read strobe, clears ready |
| rx_byte0 | output | 8 | First recovered byte |
| rx_byte1 | output | 8 | Second recovered byte |
| par_err0 | output | 1 | Parity error, first byte |
| par_err1 | output | 1 | Parity error, second byte |
| data_ready | output | 1 | Byte pair available |
| data_level | output | 8 | Data threshold in use |
| sync_level | output | 8 | Sync threshold in use |
| sync_slice | output | 1 | Sample below sync threshold |

## Verification
Each result has a fixed latency:
- The data level changes one cycle after position RUNIN_END.
- The sync level changes one cycle after position BLANK_POS.
- The bytes, parity flags and ready flag change together, one cycle after the sixteenth data-bit centre.
- `sync_slice` follows its sample by one cycle.

The bench drives on falling edges and samples on the next falling edge, so each registered result is read one full cycle after its stimulus. Thresholds and bytes are sticky, so they are compared after the whole field has been sent. A monitor pops the expected byte pair from the queue on the rising edge of `data_ready`, which catches the capture in the cycle it happens.

// File: rtl/cc_slicer_pkg.sv
package cc_slicer_pkg;
  localparam int SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_DATA} rx_state_e;

  localparam sample_t DATA_LVL_RST = 8'h80;
  localparam sample_t SYNC_LVL_RST = 8'h40;

  // floor of the average of two samples, carried through one extra bit
  function automatic sample_t mid_level(input sample_t a, input sample_t b);
    logic [SAMPLE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SAMPLE_W:1];
  endfunction

  // 1 when the byte fails odd parity
  function automatic logic parity_bad(input logic [7:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/cc_line_timer.sv
module cc_line_timer #(
  parameter int LINE_W = 6,
  parameter int POS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  output logic [LINE_W-1:0] line_cnt,
  output logic [POS_W-1:0]  pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      pos      <= '1;   // parked until the first line pulse
    end else begin
      if (vsync)                          line_cnt <= '0;
      else if (hsync && line_cnt != '1)   line_cnt <= line_cnt + 1'b1;
      if (hsync)          pos <= '0;
      else if (pos != '1) pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/cc_sync_level.sv
module cc_sync_level
  import cc_slicer_pkg::*;
#(
  parameter int POS_W     = 9,
  parameter int SYNC_LEN  = 8,
  parameter int BLANK_POS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sample_t          vid,
  input  logic [POS_W-1:0] pos,
  output sample_t          auto_lvl,
  output logic             latch
);
  localparam logic [POS_W-1:0] TIP_END = POS_W'(SYNC_LEN);
  localparam logic [POS_W-1:0] BLK_POS = POS_W'(BLANK_POS);

  sample_t tip_min;
  assign latch = (pos == BLK_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tip_min  <= '1;
      auto_lvl <= SYNC_LVL_RST;
    end else begin
      if (pos == '0)                            tip_min <= vid;
      else if (pos < TIP_END && vid < tip_min)  tip_min <= vid;
      if (latch) auto_lvl <= mid_level(tip_min, vid);
    end
  end
endmodule

// File: rtl/cc_data_level.sv
module cc_data_level
  import cc_slicer_pkg::*;
#(
  parameter int POS_W       = 9,
  parameter int RUNIN_START = 16,
  parameter int RUNIN_END   = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sample_t          vid,
  input  logic [POS_W-1:0] pos,
  input  logic             on_target,
  output sample_t          auto_lvl,
  output logic             runin_done
);
  localparam logic [POS_W-1:0] RS = POS_W'(RUNIN_START);
  localparam logic [POS_W-1:0] RE = POS_W'(RUNIN_END);

  sample_t pk, tr;
  logic    in_burst;
  assign in_burst   = on_target && pos >= RS && pos < RE;
  assign runin_done = on_target && pos == RE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk       <= '0;
      tr       <= '1;
      auto_lvl <= DATA_LVL_RST;
    end else begin
      if (in_burst) begin
        if (pos == RS || vid > pk) pk <= vid;
        if (pos == RS || vid < tr) tr <= vid;
      end
      if (runin_done) auto_lvl <= mid_level(pk, tr);
    end
  end
endmodule

// File: rtl/cc_bit_rx.sv
module cc_bit_rx
  import cc_slicer_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int NBYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hsync,
  input  logic                   start,
  input  sample_t                vid,
  input  sample_t                level,
  input  logic [PER_W-1:0]       period,
  output logic [NBYTES-1:0][7:0] bytes_q,
  output logic [NBYTES-1:0]      perr_q,
  output logic                   cap
);
  localparam int FRAME_BITS = 8 * NBYTES;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  rx_state_e              state;
  logic [PER_W-1:0]       bc;
  logic [1:0]             hist;
  logic [FRAME_BITS-1:0]  sh, nxt;
  logic [CNT_W-1:0]       cnt;
  logic                   tick, bit_now;

  assign tick    = (state != RX_IDLE) && (bc == (period >> 1));
  assign bit_now = (vid >= level);
  assign nxt     = {bit_now, sh[FRAME_BITS-1:1]};
  assign cap     = tick && state == RX_DATA && cnt == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      bc    <= '0;
      hist  <= 2'b11;
      sh    <= '0;
      cnt   <= '0;
    end else if (hsync) begin
      state <= RX_IDLE;
    end else if (start) begin
      state <= RX_HUNT;
      bc    <= '0;
      hist  <= 2'b11;
    end else if (state != RX_IDLE) begin
      bc <= (bc == period - PER_W'(1)) ? '0 : bc + 1'b1;
      if (tick) begin
        if (state == RX_HUNT) begin
          hist <= {hist[0], bit_now};
          if ({hist, bit_now} == 3'b001) begin
            state <= RX_DATA;
            cnt   <= '0;
          end
        end else begin
          sh  <= nxt;
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= RX_IDLE;
        end
      end
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[b] <= '0;
        perr_q[b]  <= 1'b0;
      end else if (cap) begin
        bytes_q[b] <= nxt[b*8 +: 8];
        perr_q[b]  <= parity_bad(nxt[b*8 +: 8]);
      end
    end
  end
endmodule

// File: rtl/cc_slicer.sv
module cc_slicer
  import cc_slicer_pkg::*;
#(
  parameter int LINE_W      = 6,
  parameter int POS_W       = 9,
  parameter int PER_W       = 8,
  parameter int SYNC_LEN    = 8,
  parameter int BLANK_POS   = 12,
  parameter int RUNIN_START = 16,
  parameter int RUNIN_END   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        vid,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [PER_W-1:0]  cfg_bit_period,
  input  logic              data_auto,
  input  logic [7:0]        data_level_man,
  input  logic              sync_auto,
  input  logic [7:0]        sync_level_man,
  input  logic              status_rd,
  output logic [7:0]        rx_byte0,
  output logic [7:0]        rx_byte1,
  output logic              par_err0,
  output logic              par_err1,
  output logic              data_ready,
  output logic [7:0]        data_level,
  output logic [7:0]        sync_level,
  output logic              sync_slice
);
  logic [LINE_W-1:0] line_cnt;
  logic [POS_W-1:0]  pos;
  logic              on_target, runin_done, sync_latch, cap;
  sample_t           auto_dlvl, auto_slvl;
  logic [1:0][7:0]   rx_bytes;
  logic [1:0]        rx_perr;

  cc_line_timer #(.LINE_W(LINE_W), .POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .line_cnt(line_cnt), .pos(pos));

  assign on_target = (line_cnt == cfg_line);

  cc_sync_level #(.POS_W(POS_W), .SYNC_LEN(SYNC_LEN), .BLANK_POS(BLANK_POS)) u_sync (
    .clk(clk), .rst_n(rst_n), .vid(vid), .pos(pos),
    .auto_lvl(auto_slvl), .latch(sync_latch));

  cc_data_level #(.POS_W(POS_W), .RUNIN_START(RUNIN_START), .RUNIN_END(RUNIN_END)) u_dlvl (
    .clk(clk), .rst_n(rst_n), .vid(vid), .pos(pos), .on_target(on_target),
    .auto_lvl(auto_dlvl), .runin_done(runin_done));

  assign data_level = data_auto ? auto_dlvl : data_level_man;
  assign sync_level = sync_auto ? auto_slvl : sync_level_man;

  cc_bit_rx #(.PER_W(PER_W), .NBYTES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .start(runin_done),
    .vid(vid), .level(data_level), .period(cfg_bit_period),
    .bytes_q(rx_bytes), .perr_q(rx_perr), .cap(cap));

  assign rx_byte0 = rx_bytes[0];
  assign rx_byte1 = rx_bytes[1];
  assign par_err0 = rx_perr[0];
  assign par_err1 = rx_perr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ready <= 1'b0;
      sync_slice <= 1'b0;
    end else begin
      if (cap)            data_ready <= 1'b1;
      else if (status_rd) data_ready <= 1'b0;
      sync_slice <= (vid < sync_level);
    end
  end
endmodule

// File: rtl/cc_slicer_chk.sv
module cc_slicer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cap,
  input logic       on_target,
  input logic       runin_done,
  input logic [7:0] auto_dlvl,
  input logic       sync_latch,
  input logic [7:0] auto_slvl,
  input logic       status_rd,
  input logic       data_ready,
  input logic [7:0] rx_byte0,
  input logic [7:0] rx_byte1,
  input logic       par_err0,
  input logic       par_err1
);
  p_cap_on_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> on_target);
  p_dlvl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !runin_done |=> $stable(auto_dlvl));
  p_bytes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(rx_byte0) && $stable(rx_byte1)));
  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (par_err0 == ($countones(rx_byte0) % 2 == 0)) &&
            (par_err1 == ($countones(rx_byte1) % 2 == 0)));
  p_ready_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> data_ready);
  p_ready_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !cap) |=> !data_ready);
  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_rd && !cap) |=> $stable(data_ready));
  p_slvl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_latch |=> $stable(auto_slvl));
endmodule

bind cc_slicer cc_slicer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap(cap), .on_target(on_target),
  .runin_done(runin_done), .auto_dlvl(auto_dlvl), .sync_latch(sync_latch),
  .auto_slvl(auto_slvl), .status_rd(status_rd), .data_ready(data_ready),
  .rx_byte0(rx_byte0), .rx_byte1(rx_byte1), .par_err0(par_err0),
  .par_err1(par_err1));

// File: tb/cc_slicer_bench.sv
`timescale 1ns/1ps
module cc_slicer_bench;
  localparam int P      = 6;
  localparam int LEN    = 190;
  localparam int SYNC_N = 8;
  localparam int RS     = 16;
  localparam int RE     = 40;
  localparam int TGT    = 3;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] vid = 8'h40;
  logic       hsync = 1'b0, vsync = 1'b0;
  logic [5:0] cfg_line = 6'(TGT);
  logic [7:0] cfg_bit_period = 8'(P);
  logic       data_auto = 1'b1, sync_auto = 1'b1, status_rd = 1'b0;
  logic [7:0] data_level_man = 8'h60, sync_level_man = 8'h30;
  logic [7:0] rx_byte0, rx_byte1, data_level, sync_level;
  logic       par_err0, par_err1, data_ready, sync_slice;

  int n_chk = 0, n_bad = 0;

  typedef struct {logic [7:0] b0, b1; logic pe0, pe1;} exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  cc_slicer u_cc_slicer (
    .clk(clk), .rst_n(rst_n), .vid(vid), .hsync(hsync), .vsync(vsync),
    .cfg_line(cfg_line), .cfg_bit_period(cfg_bit_period),
    .data_auto(data_auto), .data_level_man(data_level_man),
    .sync_auto(sync_auto), .sync_level_man(sync_level_man),
    .status_rd(status_rd), .rx_byte0(rx_byte0), .rx_byte1(rx_byte1),
    .par_err0(par_err0), .par_err1(par_err1), .data_ready(data_ready),
    .data_level(data_level), .sync_level(sync_level), .sync_slice(sync_slice));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] avg(input logic [7:0] a, input logic [7:0] b);
    return 8'((int'(a) + int'(b)) / 2);
  endfunction

  task automatic put(input logic [7:0] v, input logic h, input logic vs);
    @(negedge clk);
    vid = v; hsync = h; vsync = vs;
  endtask

  task automatic send_line(input logic [7:0] tip, input bit data,
                           input logic [7:0] rhi, input logic [7:0] rlo,
                           input logic [15:0] payload, input logic [7:0] pre,
                           input int npre);
    put(8'h40, 1'b1, 1'b0);
    for (int p = 0; p < LEN; p++) begin
      logic [7:0] v;
      int k;
      bit b;
      if (p < SYNC_N)      v = (p == 3) ? tip : tip + 8'd5;
      else if (!data)      v = 8'h40;
      else if (p >= RS && p < RE) v = ((p / 3) % 2 == 1) ? rhi : rlo;
      else if (p <= RE)    v = 8'h40;
      else begin
        k = (p - RE - 1) / P;
        if (k < npre)           b = pre[k];
        else if (k < npre + 16) b = payload[k - npre];
        else                    b = 1'b0;
        v = b ? 8'h90 : 8'h50;
      end
      put(v, 1'b0, 1'b0);
    end
  endtask

  // driver: one field of four lines, data placed on line dline
  task automatic run_field(input int dline, input logic [7:0] tip,
                           input logic [7:0] rhi, input logic [7:0] rlo,
                           input logic [15:0] payload, input logic [7:0] pre,
                           input int npre, input bit expect_cap);
    if (expect_cap) begin
      exp_t e;
      e.b0 = payload[7:0];
      e.b1 = payload[15:8];
      e.pe0 = ($countones(payload[7:0]) % 2 == 0);
      e.pe1 = ($countones(payload[15:8]) % 2 == 0);
      sb.push_back(e);
    end
    put(8'h40, 1'b0, 1'b1);
    for (int ln = 1; ln <= 4; ln++)
      send_line(tip, ln == dline, rhi, rlo, payload, pre, npre);
    put(8'h40, 1'b0, 1'b0);
    chk("R8 ready after field", {31'd0, data_ready}, {31'd0, expect_cap});
    chk("R9 auto sync level", {24'd0, sync_level}, {24'd0, avg(tip, 8'h40)});
  endtask

  task automatic clear_ready();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk("R8 ready cleared by status read", {31'd0, data_ready}, 32'd0);
  endtask

  // monitor: pop expected pair when ready rises
  logic rdy_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && data_ready && !rdy_prev) begin
      if (sb.size() == 0) begin
        chk("R1 unexpected capture", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R6 byte0", {24'd0, rx_byte0}, {24'd0, e.b0});
        chk("R6 byte1", {24'd0, rx_byte1}, {24'd0, e.b1});
        chk("R7 parity0", {31'd0, par_err0}, {31'd0, e.pe0});
        chk("R7 parity1", {31'd0, par_err1}, {31'd0, e.pe1});
      end
    end
    rdy_prev <= data_ready;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 byte0 reset", {24'd0, rx_byte0}, 32'd0);
    chk("R11 byte1 reset", {24'd0, rx_byte1}, 32'd0);
    chk("R8 ready reset", {31'd0, data_ready}, 32'd0);
    chk("R2 data level reset", {24'd0, data_level}, 32'h80);
    chk("R9 sync level reset", {24'd0, sync_level}, 32'h40);

    // R1 R2 R4 R5: automatic level, plain start pattern, good parity
    run_field(TGT, 8'h10, 8'hC8, 8'h30, 16'h52C1, 8'b100, 3, 1'b1);
    chk("R2 auto data level", {24'd0, data_level}, {24'd0, avg(8'hC8, 8'h30)});
    clear_ready();
    chk("R6 bytes kept after read", {24'd0, rx_byte0}, 32'hC1);

    // R5 R7: misleading prefix 0,1,0,0,1 and a parity error on byte0
    run_field(TGT, 8'h20, 8'hC8, 8'h30, 16'h8003, 8'b10010, 5, 1'b1);
    clear_ready();

    // R1: data on a line other than the selected one
    run_field(2, 8'h10, 8'hC8, 8'h30, 16'h52C1, 8'b100, 3, 1'b0);
    chk("R1 wrong line keeps bytes", {24'd0, rx_byte0}, 32'h03);

    // R2 R4: automatic level from a high burst slices every bit to 0
    run_field(TGT, 8'h10, 8'hF0, 8'hE0, 16'hFE15, 8'b100, 3, 1'b0);
    chk("R2 high burst level", {24'd0, data_level}, 32'hE8);

    // R3: manual level recovers the same line
    data_auto = 1'b0;
    run_field(TGT, 8'h10, 8'hF0, 8'hE0, 16'hFE15, 8'b100, 3, 1'b1);
    chk("R3 manual data level", {24'd0, data_level}, 32'h60);
    clear_ready();

    // R9 R10: manual sync level and sync slicing
    sync_auto = 1'b0;
    @(negedge clk);
    chk("R9 manual sync level", {24'd0, sync_level}, 32'h30);
    put(8'h10, 1'b0, 1'b0);
    put(8'h30, 1'b0, 1'b0);
    chk("R10 below level slices high", {31'd0, sync_slice}, 32'd1);
    put(8'h50, 1'b0, 1'b0);
    chk("R10 equal level slices low", {31'd0, sync_slice}, 32'd0);
    put(8'h50, 1'b0, 1'b0);
    chk("R10 above level slices low", {31'd0, sync_slice}, 32'd0);

    chk("R6 all expected pairs seen", sb.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule